// File: doc/BRIEF.md
# Four-Tap FIR Filter Stage with Internal Delay Line

This block is one stage of a finite impulse response filter. It holds its own tap delay line and its own coefficient registers, and it multiplies each tap by its coefficient in four signed 18x18 multipliers. It sums the four products to a full-precision 38-bit result. The output is registered after the multiply step and again after the add step. A sample enters the delay line only when its valid strobe is high. The newest sample sits in tap 0.

Coefficients can be loaded in two ways. The first shifts one word per strobe through a coefficient chain. The second writes all four words from a wide bus in a single cycle. The oldest tap is driven out on a cascade port. A second stage can take its delay-line input from that port, which extends the delay line. An adder outside the block then sums the stage outputs to build filters longer than four taps.

Top module: `fir4_stage`

## Requirements
- R1: A synchronous reset clears the delay line, the coefficient registers, the product and sum registers and the valid pipeline; `out_valid_o`, `out_data_o` and `casc_data_o` read zero afterwards.
- R2: The delay line shifts only on a rising edge where `smp_valid_i` is 1. Tap 0 takes `smp_data_i` when `chain_sel_i` is 0 and `casc_data_i` when it is 1.
- R3: `casc_data_o` always equals tap 3, which is the sample accepted four valid edges earlier. It does not change on edges without `smp_valid_i`.
- R4: The filtered result is the signed two's-complement sum over k of tap[k] x coef[k], where tap 0 is the newest sample. It is computed at full precision in 38 bits.
- R5: A sample accepted at rising edge E drives `out_valid_o` high for exactly one cycle, after edge E+1. `out_data_o` holds its last value while no result is due.
- R6: When `coef_load_i` is 1 and `coef_mode_i` is 0 (serial), coef[0] takes `coef_ser_i` and coef[k] takes coef[k-1]. After four strobes the first word loaded is in coef[3].
- R7: When `coef_load_i` is 1 and `coef_mode_i` is 1 (parallel), coef[k] takes bits [18k+17:18k] of `coef_par_i` for every k, all at one edge.
- R8: The products for a sample use the coefficient values held before the edge that accepts it. A load at that same edge applies only to samples accepted at later edges.
- R9: A sample accepted at an edge that also performs a serial coefficient shift produces no `out_valid_o` pulse. The sample still enters the delay line.
- R10: The extreme product case does not overflow. Four taps and four coefficients of -131072 give +2^36.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid_i | input | 1 | Accepts one sample into the delay line |
| smp_data_i | input | 18 | Signed sample from the local source |
| chain_sel_i | input | 1 | Delay-line head source: 0 local sample, 1 cascade input |
| casc_data_i | input | 18 | Oldest tap from the previous stage |
| casc_data_o | output | 18 | Oldest tap of this stage, for the next stage |
| coef_load_i | input | 1 | Coefficient load strobe |
| coef_mode_i | input | 1 | 0 serial shift, 1 parallel write |
| coef_ser_i | input | 18 | Serial coefficient word |
| coef_par_i | input | 72 | Parallel coefficient words, tap k in bits [18k+17:18k] |
| out_valid_o | output | 1 | Filtered result valid |
| out_data_o | output | 38 | Signed filtered result |

## Verification
The delay-line output `casc_data_o` is due right after the accepting edge. The filtered result and its valid pulse are due after the second rising edge. Coefficient loads change only the products of samples accepted after the loading edge. The bench drives its inputs after a falling edge and steps its reference model at the same rising edge the design uses. It compares valid, data and cascade output at the next falling edge, so every expected value is due at that instant with the pipeline depth already counted in the model.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

   typedef enum logic {
      COEF_SERIAL   = 1'b0,
      COEF_PARALLEL = 1'b1
   } coef_mode_e;

   function automatic int sum_width(input int prod_w, input int n_taps);
      return prod_w + $clog2(n_taps);
   endfunction

endpackage

// File: rtl/fir4_delay_line.sv
module fir4_delay_line #(
   parameter int DATA_W   = 18,
   parameter int NUM_TAPS = 4
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             shift_i,
   input  logic [DATA_W-1:0]                head_i,
   output logic [NUM_TAPS-1:0][DATA_W-1:0]  taps_q_o,
   output logic [NUM_TAPS-1:0][DATA_W-1:0]  taps_nxt_o
);

   logic [NUM_TAPS-1:0][DATA_W-1:0] taps_q;
   logic [NUM_TAPS-1:0][DATA_W-1:0] taps_nxt;

   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
      if (k == 0) begin : g_head
         assign taps_nxt[k] = shift_i ? head_i : taps_q[k];
      end else begin : g_body
         assign taps_nxt[k] = shift_i ? taps_q[k-1] : taps_q[k];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) taps_q <= '0;
      else     taps_q <= taps_nxt;
   end

   assign taps_q_o   = taps_q;
   assign taps_nxt_o = taps_nxt;

endmodule

// File: rtl/fir4_coef_bank.sv
module fir4_coef_bank
   import fir4_pkg::*;
#(
   parameter int COEF_W   = 18,
   parameter int NUM_TAPS = 4
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             load_i,
   input  logic                             mode_i,
   input  logic [COEF_W-1:0]                ser_i,
   input  logic [NUM_TAPS*COEF_W-1:0]       par_i,
   output logic [NUM_TAPS-1:0][COEF_W-1:0]  coef_o,
   output logic                             ser_shift_o
);

   coef_mode_e                      mode;
   logic [NUM_TAPS-1:0][COEF_W-1:0] coef_q;
   logic [NUM_TAPS-1:0][COEF_W-1:0] coef_nxt;
   logic                            ser_shift;
   logic                            par_write;

   assign mode      = coef_mode_e'(mode_i);
   assign ser_shift = load_i && (mode == COEF_SERIAL);
   assign par_write = load_i && (mode == COEF_PARALLEL);

   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_coef
      logic [COEF_W-1:0] shift_src;
      if (k == 0) begin : g_first
         assign shift_src = ser_i;
      end else begin : g_rest
         assign shift_src = coef_q[k-1];
      end
      always_comb begin
         if (par_write)      coef_nxt[k] = par_i[k*COEF_W +: COEF_W];
         else if (ser_shift) coef_nxt[k] = shift_src;
         else                coef_nxt[k] = coef_q[k];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) coef_q <= '0;
      else     coef_q <= coef_nxt;
   end

   assign coef_o      = coef_q;
   assign ser_shift_o = ser_shift;

endmodule

// File: rtl/fir4_mac.sv
module fir4_mac #(
   parameter int DATA_W   = 18,
   parameter int COEF_W   = 18,
   parameter int NUM_TAPS = 4,
   parameter int OUT_W    = 38
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             accept_i,
   input  logic                             keep_i,
   input  logic [NUM_TAPS-1:0][DATA_W-1:0]  taps_i,
   input  logic [NUM_TAPS-1:0][COEF_W-1:0]  coef_i,
   output logic                             valid_o,
   output logic [OUT_W-1:0]                 sum_o
);

   localparam int PROD_W = DATA_W + COEF_W;

   logic [NUM_TAPS-1:0][PROD_W-1:0] prod_q;
   logic [NUM_TAPS-1:0][PROD_W-1:0] prod_d;
   logic                            pv_q;
   logic                            ov_q;
   logic signed [OUT_W-1:0]         acc;
   logic [OUT_W-1:0]                sum_q;

   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_mul
      logic signed [PROD_W-1:0] a_ext;
      logic signed [PROD_W-1:0] b_ext;
      assign a_ext     = PROD_W'($signed(taps_i[k]));
      assign b_ext     = PROD_W'($signed(coef_i[k]));
      assign prod_d[k] = a_ext * b_ext;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prod_q <= '0;
         pv_q   <= 1'b0;
      end else begin
         pv_q <= accept_i && keep_i;
         if (accept_i) prod_q <= prod_d;
      end
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < NUM_TAPS; k++) begin
         acc = acc + OUT_W'($signed(prod_q[k]));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q <= '0;
         ov_q  <= 1'b0;
      end else begin
         ov_q <= pv_q;
         if (pv_q) sum_q <= acc;
      end
   end

   assign valid_o = ov_q;
   assign sum_o   = sum_q;

endmodule

// File: rtl/fir4_stage.sv
module fir4_stage #(
   parameter int DATA_W   = 18,
   parameter int COEF_W   = 18,
   parameter int NUM_TAPS = 4,
   parameter int OUT_W    = fir4_pkg::sum_width(DATA_W + COEF_W, NUM_TAPS)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       smp_valid_i,
   input  logic [DATA_W-1:0]          smp_data_i,
   input  logic                       chain_sel_i,
   input  logic [DATA_W-1:0]          casc_data_i,
   output logic [DATA_W-1:0]          casc_data_o,
   input  logic                       coef_load_i,
   input  logic                       coef_mode_i,
   input  logic [COEF_W-1:0]          coef_ser_i,
   input  logic [NUM_TAPS*COEF_W-1:0] coef_par_i,
   output logic                       out_valid_o,
   output logic [OUT_W-1:0]           out_data_o
);

   localparam int MIN_OUT_W = fir4_pkg::sum_width(DATA_W + COEF_W, NUM_TAPS);

   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("fir4_stage: DATA_W and COEF_W must be at least 2");
   end
   if (NUM_TAPS < 1 || NUM_TAPS > 4) begin : g_bad_taps
      $error("fir4_stage: NUM_TAPS must lie in 1..4");
   end
   if (OUT_W < MIN_OUT_W) begin : g_bad_out
      $error("fir4_stage: OUT_W too narrow for full precision");
   end

   logic [DATA_W-1:0]                head;
   logic [NUM_TAPS-1:0][DATA_W-1:0]  taps_q;
   logic [NUM_TAPS-1:0][DATA_W-1:0]  taps_nxt;
   logic [NUM_TAPS-1:0][COEF_W-1:0]  coef;
   logic                             ser_shift;

   assign head = chain_sel_i ? casc_data_i : smp_data_i;

   fir4_delay_line #(
      .DATA_W   (DATA_W),
      .NUM_TAPS (NUM_TAPS)
   ) u_line (
      .clk        (clk),
      .rst        (rst),
      .shift_i    (smp_valid_i),
      .head_i     (head),
      .taps_q_o   (taps_q),
      .taps_nxt_o (taps_nxt)
   );

   fir4_coef_bank #(
      .COEF_W   (COEF_W),
      .NUM_TAPS (NUM_TAPS)
   ) u_coef (
      .clk         (clk),
      .rst         (rst),
      .load_i      (coef_load_i),
      .mode_i      (coef_mode_i),
      .ser_i       (coef_ser_i),
      .par_i       (coef_par_i),
      .coef_o      (coef),
      .ser_shift_o (ser_shift)
   );

   fir4_mac #(
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W),
      .NUM_TAPS (NUM_TAPS),
      .OUT_W    (OUT_W)
   ) u_mac (
      .clk      (clk),
      .rst      (rst),
      .accept_i (smp_valid_i),
      .keep_i   (!ser_shift),
      .taps_i   (taps_nxt),
      .coef_i   (coef),
      .valid_o  (out_valid_o),
      .sum_o    (out_data_o)
   );

   assign casc_data_o = taps_q[NUM_TAPS-1];

endmodule

// File: rtl/fir4_stage_chk.sv
module fir4_stage_chk #(
   parameter int DATA_W = 18,
   parameter int OUT_W  = 38
) (
   input logic              clk,
   input logic              rst,
   input logic              smp_valid_i,
   input logic              coef_load_i,
   input logic              coef_mode_i,
   input logic              out_valid_o,
   input logic [OUT_W-1:0]  out_data_o,
   input logic [DATA_W-1:0] casc_data_o
);

   logic kept;
   assign kept = smp_valid_i && !(coef_load_i && !coef_mode_i);

   // R1: outputs read zero one edge after reset is sampled
   p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid_o && out_data_o == '0 && casc_data_o == '0));

   // R3: cascade output holds on edges without a sample
   p_casc_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !smp_valid_i |=> $stable(casc_data_o));

   // R5: kept sample yields a valid pulse after the second edge
   p_latency_r5: assert property (@(posedge clk) disable iff (rst)
      kept |=> ##1 out_valid_o);

   // R9: every pulse traces back to a sample without a serial shift
   p_pulse_origin_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid_o |-> ($past(smp_valid_i, 2) && !$past(coef_load_i && !coef_mode_i, 2)));

   // R5: data holds while no result is delivered
   p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!out_valid_o && !$past(rst)) |-> $stable(out_data_o));

endmodule

bind fir4_stage fir4_stage_chk #(
   .DATA_W (DATA_W),
   .OUT_W  (OUT_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .smp_valid_i (smp_valid_i),
   .coef_load_i (coef_load_i),
   .coef_mode_i (coef_mode_i),
   .out_valid_o (out_valid_o),
   .out_data_o  (out_data_o),
   .casc_data_o (casc_data_o)
);

// File: tb/fir4_stage_test.sv
`timescale 1ns/1ps
module fir4_stage_test;

   localparam int DW = 18;
   localparam int CW = 18;
   localparam int NT = 4;
   localparam int OW = 38;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               smp_valid = 1'b0;
   logic [DW-1:0]      smp_data = '0;
   logic               chain_sel = 1'b0;
   logic [DW-1:0]      casc_in = '0;
   logic [DW-1:0]      casc_out;
   logic               coef_load = 1'b0;
   logic               coef_mode = 1'b0;
   logic [CW-1:0]      coef_ser = '0;
   logic [NT*CW-1:0]   coef_par = '0;
   logic               out_valid;
   logic [OW-1:0]      out_data;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req  = "R1";

   longint m_tap[NT];
   longint m_coef[NT];
   longint m_prod_sum;
   bit     m_pv;
   bit     m_ov;
   longint m_sum;

   always #2.5 clk = ~clk;

   fir4_stage uut (
      .clk         (clk),
      .rst         (rst),
      .smp_valid_i (smp_valid),
      .smp_data_i  (smp_data),
      .chain_sel_i (chain_sel),
      .casc_data_i (casc_in),
      .casc_data_o (casc_out),
      .coef_load_i (coef_load),
      .coef_mode_i (coef_mode),
      .coef_ser_i  (coef_ser),
      .coef_par_i  (coef_par),
      .out_valid_o (out_valid),
      .out_data_o  (out_data)
   );

   function automatic longint s18(input logic [17:0] v);
      return longint'($signed(v));
   endfunction

   task automatic model_edge();
      if (rst) begin
         foreach (m_tap[k])  m_tap[k]  = 0;
         foreach (m_coef[k]) m_coef[k] = 0;
         m_prod_sum = 0; m_pv = 0; m_ov = 0; m_sum = 0;
         return;
      end
      m_ov = m_pv;
      if (m_pv) m_sum = m_prod_sum;
      if (smp_valid) begin
         for (int k = NT-1; k > 0; k--) m_tap[k] = m_tap[k-1];
         m_tap[0] = chain_sel ? s18(casc_in) : s18(smp_data);
         m_prod_sum = 0;
         for (int k = 0; k < NT; k++) m_prod_sum += m_tap[k] * m_coef[k];
         m_pv = !(coef_load && !coef_mode);
      end else begin
         m_pv = 0;
      end
      if (coef_load && coef_mode) begin
         for (int k = 0; k < NT; k++) m_coef[k] = s18(coef_par[k*CW +: CW]);
      end else if (coef_load) begin
         for (int k = NT-1; k > 0; k--) m_coef[k] = m_coef[k-1];
         m_coef[0] = s18(coef_ser);
      end
   endtask

   task automatic compare();
      longint got;
      n_checks++;
      if (out_valid !== m_ov) begin
         n_errors++;
         $display("FAIL %s/R5 out_valid actual=%0b expected=%0b", cur_req, out_valid, m_ov);
      end
      n_checks++;
      got = longint'($signed(out_data));
      if (got != m_sum) begin
         n_errors++;
         $display("FAIL %s/R4 out_data actual=%0d expected=%0d", cur_req, got, m_sum);
      end
      n_checks++;
      if (s18(casc_out) != m_tap[NT-1]) begin
         n_errors++;
         $display("FAIL %s/R3 casc_data actual=%0d expected=%0d", cur_req, s18(casc_out), m_tap[NT-1]);
      end
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      smp_valid = 1'b0;
      coef_load = 1'b0;
   endtask

   task automatic sample(input longint v);
      smp_valid = 1'b1;
      smp_data  = DW'(v);
      step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic par_load(input longint c0, input longint c1, input longint c2, input longint c3);
      coef_load = 1'b1;
      coef_mode = 1'b1;
      coef_par  = {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_errors++;
      $display("FAIL watchdog expired in phase %s", cur_req);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : stim
      logic [15:0] lfsr;
      @(negedge clk);
      cur_req = "R1";
      idle(3);
      rst = 1'b0;
      idle(1);
      sample(77);
      idle(3);

      cur_req = "R7";
      par_load(1, 2, 3, 4);
      step();
      sample(1);
      idle(2);
      sample(0); sample(0); sample(0); sample(0);
      idle(3);

      cur_req = "R2";
      sample(10); idle(2); sample(-20); idle(1); sample(30);
      sample(-40); idle(4); sample(50);
      idle(3);

      cur_req = "R3";
      for (int i = 0; i < 6; i++) begin
         sample(100 + i);
         idle(i % 3);
      end
      idle(3);

      cur_req = "R6";
      coef_mode = 1'b0;
      for (int i = 0; i < 4; i++) begin
         coef_load = 1'b1;
         coef_ser  = CW'(-(i + 5));
         step();
      end
      sample(3); sample(-7); sample(11); sample(2);
      idle(3);

      cur_req = "R9";
      coef_load = 1'b1; coef_mode = 1'b0; coef_ser = CW'(9);
      sample(21);
      coef_load = 1'b1; coef_mode = 1'b0; coef_ser = CW'(-9);
      sample(-33);
      sample(4);
      idle(3);

      cur_req = "R8";
      par_load(7, -3, 5, 2);
      sample(13);
      par_load(-1, 1, -1, 1);
      sample(17);
      sample(19);
      idle(3);

      cur_req = "R10";
      par_load(-131072, -131072, -131072, -131072);
      step();
      for (int i = 0; i < 4; i++) sample(-131072);
      idle(2);
      par_load(131071, 131071, 131071, 131071);
      step();
      for (int i = 0; i < 4; i++) sample(-131072);
      idle(3);

      cur_req = "R2";
      par_load(1, 10, 100, 1000);
      step();
      chain_sel = 1'b1;
      for (int i = 0; i < 5; i++) begin
         casc_in = DW'(i * 3 - 4);
         smp_data = DW'(999);
         smp_valid = 1'b1;
         step();
      end
      chain_sel = 1'b0;
      idle(3);

      cur_req = "R4";
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         smp_valid = lfsr[0] | lfsr[1];
         smp_data  = {lfsr[1:0], lfsr};
         chain_sel = lfsr[5] & lfsr[6] & lfsr[7];
         casc_in   = {lfsr[15:0], lfsr[3:2]};
         coef_load = (lfsr[9:8] == 2'b11);
         coef_mode = lfsr[4];
         coef_ser  = {lfsr[3:2], ~lfsr};
         coef_par  = {4{lfsr[11:0], lfsr[15:10]}};
         step();
      end
      chain_sel = 1'b0;
      idle(3);

      cur_req = "R1";
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      idle(1);
      sample(5);
      idle(3);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule